// File: doc/BRIEF.md
# I2C serial EEPROM target

This block is a two-wire serial bus target placed in front of a small on-chip byte memory held in registers. It behaves the way a serial EEPROM does. It takes an oversampled serial clock and the data line from the bus, along with a write-protect level. It drives one output, an open-drain pull-down enable for the data line, so it can only pull the line low or release it. Both bus lines pass through a two-flop synchronizer and then through an edge detector that runs on the system clock. The system clock must run at least 8 times faster than the serial clock.

Every transaction opens with a control byte. The top nibble of that byte is the fixed device code 1010. The next bits hold high-order memory address bits. The least significant bit selects read (1) or write (0).

The block keeps an internal address pointer that persists from one transaction to the next, which gives three kinds of read:
- A read with no address phase returns the byte at the pointer.
- A write control byte followed by a word address and a repeated START performs a random read.
- A master ACK after each byte keeps a sequential read going, and the pointer wraps at the top of memory.

While write protect is high, bytes are still acknowledged but memory does not change.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A falling data line while the serial clock is high (START) puts the block into control-byte reception at any time. A rising data line while the clock is high (STOP) returns it to idle with the data line released.
- R2: A control byte whose bits 7:4 equal 1010 is acknowledged by pulling the data line low during the ninth clock. Any other code gets no acknowledge, and the block then ignores the bus until the next START.
- R3: After a write control byte, the next byte is the word address. It is acknowledged and sets the pointer to {control bits [ADDR_W-8:1], word address}. Each following data byte is acknowledged, written at the pointer, and advances the pointer by one.
- R4: A write control byte, a word address, a repeated START and a read control byte return the byte stored at that address.
- R5: A read control byte with no address phase returns the byte at the current pointer. The pointer advances by one after every byte sent and keeps its value across transactions.
- R6: In a read, a master ACK after a data byte makes the block send the byte at the next address. A master NO ACK makes it release the line and wait for START or STOP.
- R7: The pointer wraps from address 2^ADDR_W-1 to 0 on increment, in both reads and writes.
- R8: While wp_i is high, all control, address and data bytes are still acknowledged, but memory stays unchanged. Reads behave normally.
- R9: The block changes its data-line pull only while the serial clock is low. It drives only a pull-down and never drives the line high.
- R10: After reset the data line is released, the pointer is 0, and the byte at address a is (7*a+3) mod 256.
- R11: A START or STOP in the middle of a byte aborts the transfer without changing the pointer or memory. A START leads straight into reception of a new control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Data line as seen on the bus |
| wp_i | input | 1 | Write protect, high blocks memory updates |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The assertions check on every cycle the properties that hold regardless of traffic:
- START and STOP move the state machine to the right state.
- The pull changes only while the synchronized clock is low.
- The pull is asserted only in acknowledge or read-data states.
- The pointer moves only by a wrapping single step or by an address load.
- No write strobe follows a protected cycle.

Only the bench scenarios can show the byte-level results. These are the values returned by random, current-address and sequential reads across the address range, including the wrap. They also cover acknowledge versus silence for good and bad device codes, memory left unchanged under write protect, and pointer preservation after mid-byte aborts.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } ee_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(i * 7 + 3);
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_ee_fsm.sv
module i2c_ee_fsm
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int HI_W = ADDR_W - 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic [7:0]        rdata_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [7:0]        wdata_o,
  output logic              sda_pull_o
);
  ee_state_e         state_q, next_q;
  logic [3:0]        cnt_q;
  logic [7:0]        sh_q, tx_q;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              mack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      next_q     <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      hi_q       <= '0;
      ptr_q      <= '0;
      mack_q     <= 1'b0;
      we_o       <= 1'b0;
      waddr_o    <= '0;
      wdata_o    <= '0;
      sda_pull_o <= 1'b0;
    end else begin
      we_o <= 1'b0;
      if (start_i) begin
        state_q    <= ST_CTRL;
        cnt_q      <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_i) begin
        state_q    <= ST_IDLE;
        cnt_q      <= '0;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_CTRL, ST_WADDR, ST_WDATA: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (state_q == ST_CTRL) begin
                if (sh_q[7:4] == DEV_CODE) begin
                  hi_q       <= sh_q[HI_W:1];
                  next_q     <= sh_q[0] ? ST_RDATA : ST_WADDR;
                  sda_pull_o <= 1'b1;
                  state_q    <= ST_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_WADDR) begin
                ptr_q      <= {hi_q, sh_q};
                next_q     <= ST_WDATA;
                sda_pull_o <= 1'b1;
                state_q    <= ST_ACK;
              end else begin
                we_o       <= ~wp_i;
                waddr_o    <= ptr_q;
                wdata_o    <= sh_q;
                ptr_q      <= ptr_q + 1'b1;
                next_q     <= ST_WDATA;
                sda_pull_o <= 1'b1;
                state_q    <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (next_q == ST_RDATA) begin
                tx_q       <= rdata_i;
                sda_pull_o <= ~rdata_i[7];
              end else begin
                sda_pull_o <= 1'b0;
              end
              state_q <= next_q;
            end
          end
          ST_RDATA: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                sda_pull_o <= 1'b0;
                ptr_q      <= ptr_q + 1'b1;
                state_q    <= ST_RACK;
              end else begin
                tx_q       <= {tx_q[6:0], 1'b0};
                sda_pull_o <= ~tx_q[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              cnt_q <= '0;
              if (mack_q) begin
                tx_q       <= rdata_i;
                sda_pull_o <= ~rdata_i[7];
                state_q    <= ST_RDATA;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign ptr_o = ptr_q;

  assert_start_ctrl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_CTRL && cnt_q == 4'd0));
  assert_stop_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_q == ST_IDLE && !sda_pull_o));
  assert_pull_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_pull_o != $past(sda_pull_o)) |-> (!scl_i || $past(start_i) || $past(stop_i)));
  assert_pull_states_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_pull_o |-> (state_q inside {ST_ACK, ST_RDATA}));
  assert_ptr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q != $past(ptr_q)) |->
      ((ptr_q == ADDR_W'($past(ptr_q) + 1'b1)) || ($past(state_q) == ST_WADDR)));
  assert_cnt_range_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 4'd8);
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_pull_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic we;
  logic [ADDR_W-1:0] ptr, waddr;
  logic [7:0] wdata, rdata;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_ee_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .wp_i       (wp_i),
    .rdata_i    (rdata),
    .ptr_o      (ptr),
    .we_o       (we),
    .waddr_o    (waddr),
    .wdata_o    (wdata),
    .sda_pull_o (sda_pull_o)
  );

  i2c_ee_mem #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (ptr),
    .rdata_o (rdata)
  );

  assert_wp_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> !$past(wp_i));
endmodule

// File: tb/i2c_eeprom_target_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_target_tb_top;
  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int Q      = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  int total = 0;
  int bad = 0;
  int r9_viol = 0;
  logic pull_prev = 1'b0;
  int exp_mem [DEPTH];

  always #5 clk = ~clk;

  i2c_eeprom_target #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .wp_i       (wp),
    .sda_pull_o (sda_pull)
  );

  always @(posedge clk) begin
    if (rst_n && (sda_pull !== pull_prev) && scl_m) r9_viol++;
    pull_prev <= sda_pull;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clk_bit(input bit b, output bit s);
    #(Q) sda_m = b;
    #(Q) scl_m = 1'b1;
    #(Q) s = sda_line;
    #(Q) scl_m = 1'b0;
  endtask

  task automatic do_start();
    #(Q) sda_m = 1'b1;
    #(Q) scl_m = 1'b1;
    #(Q) sda_m = 1'b0;
    #(Q) scl_m = 1'b0;
  endtask

  task automatic do_stop();
    #(Q) sda_m = 1'b0;
    #(Q) scl_m = 1'b1;
    #(Q) sda_m = 1'b1;
    #(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    bit s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, s);
      d = {d[6:0], s};
    end
    clk_bit(~mack, s);
  endtask

  function automatic logic [7:0] ctl(input int a, input bit rd);
    return {4'b1010, 2'b00, a[8], rd};
  endfunction

  task automatic set_addr(input int a, output bit ok);
    bit k1, k2;
    do_start();
    send_byte(ctl(a, 1'b0), k1);
    send_byte(a[7:0], k2);
    ok = k1 & k2;
  endtask

  task automatic rand_read(input int a, output logic [7:0] d, output bit ok);
    bit k1, k2;
    set_addr(a, k1);
    do_start();
    send_byte(ctl(0, 1'b1), k2);
    recv_byte(1'b0, d);
    do_stop();
    ok = k1 & k2;
  endtask

  task automatic cur_read(output logic [7:0] d, output bit ok);
    do_start();
    send_byte(ctl(0, 1'b1), ok);
    recv_byte(1'b0, d);
    do_stop();
  endtask

  initial begin
    logic [7:0] d;
    bit ok, k;
    int a, p;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = (i * 7 + 3) % 256;
    #(37);
    chk(sda_pull == 1'b0, "R10 reset pull", sda_pull, 0);
    rst_n = 1'b1;
    #(4 * Q);

    // R10 / R5: current reads from reset pointer
    cur_read(d, ok);
    chk(ok, "R2 ack ctrl read", ok, 1);
    chk(d == exp_mem[0], "R10 R5 byte at 0", d, exp_mem[0]);
    cur_read(d, ok);
    chk(d == exp_mem[1], "R5 pointer persists", d, exp_mem[1]);

    // R4: random read sweep
    for (int j = 0; j < 16; j++) begin
      a = (j * 37 + 5) % DEPTH;
      rand_read(a, d, ok);
      chk(ok && d == exp_mem[a], "R4 random read", d, exp_mem[a]);
    end
    rand_read(DEPTH - 1, d, ok);
    chk(d == exp_mem[DEPTH - 1], "R4 random read top", d, exp_mem[DEPTH - 1]);

    // R3: single-byte writes then readback
    for (int j = 0; j < 8; j++) begin
      a = (j * 61 + 9) % DEPTH;
      set_addr(a, ok);
      send_byte(8'((a ^ 8'hC3) & 8'hFF), k);
      do_stop();
      exp_mem[a] = (a ^ 8'hC3) & 8'hFF;
      chk(ok && k, "R3 write acks", {ok, k}, 3);
      rand_read(a, d, ok);
      chk(d == exp_mem[a], "R3 write readback", d, exp_mem[a]);
    end

    // R3 R7: consecutive writes wrap
    set_addr(DEPTH - 2, ok);
    send_byte(8'h11, k); send_byte(8'h22, k); send_byte(8'h33, k);
    do_stop();
    exp_mem[DEPTH - 2] = 8'h11; exp_mem[DEPTH - 1] = 8'h22; exp_mem[0] = 8'h33;

    // R6 R7: sequential read across the wrap
    set_addr(DEPTH - 2, ok);
    do_start();
    send_byte(ctl(0, 1'b1), ok);
    for (int j = 0; j < 4; j++) begin
      p = (DEPTH - 2 + j) % DEPTH;
      recv_byte(j != 3, d);
      chk(d == exp_mem[p], "R6 R7 sequential wrap", d, exp_mem[p]);
    end
    do_stop();
    chk(sda_pull == 1'b0, "R6 released after NO ACK", sda_pull, 0);
    cur_read(d, ok);
    chk(d == exp_mem[2], "R5 pointer after sequence", d, exp_mem[2]);

    // R11: STOP mid-byte keeps pointer
    rand_read(8'h40, d, ok);
    do_start();
    send_byte(ctl(0, 1'b0), ok);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, k);
    do_stop();
    cur_read(d, ok);
    chk(d == exp_mem[8'h41], "R11 abort by STOP", d, exp_mem[8'h41]);
    // R11: START mid-byte restarts control reception
    do_start();
    send_byte(ctl(0, 1'b0), ok);
    for (int i = 0; i < 3; i++) clk_bit(1'b0, k);
    do_start();
    send_byte(ctl(0, 1'b1), ok);
    recv_byte(1'b0, d);
    do_stop();
    chk(ok, "R11 ack after restart", ok, 1);
    chk(d == exp_mem[8'h42], "R11 abort by START", d, exp_mem[8'h42]);

    // R2: wrong device code ignored
    do_start();
    send_byte(8'hB0, ok);
    chk(!ok, "R2 no ack bad code", ok, 0);
    send_byte(8'h00, k);
    chk(!k, "R2 ignored after bad code", k, 0);
    do_stop();
    cur_read(d, ok);
    chk(d == exp_mem[8'h43], "R2 pointer untouched", d, exp_mem[8'h43]);

    // R8: write protect
    wp = 1'b1;
    set_addr(8'h20, ok);
    send_byte(8'hEE, k);
    do_stop();
    chk(ok && k, "R8 acks under protect", {ok, k}, 3);
    rand_read(8'h20, d, ok);
    chk(d == exp_mem[8'h20], "R8 read under protect", d, exp_mem[8'h20]);
    wp = 1'b0;
    rand_read(8'h20, d, ok);
    chk(d == exp_mem[8'h20], "R8 memory unchanged", d, exp_mem[8'h20]);

    chk(r9_viol == 0, "R9 pull change during SCL high", r9_viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule